// File: doc/BRIEF.md
# Frame-Aligned Serial Edge Counter

This block keeps a wide running count of rising edges on an external serial clock. It samples that clock in the fast system clock domain. Each edge it detects starts a fixed-width pulse. A low counter counts those pulses. When the low counter wraps, its carry advances a high counter. The count port shows the two counters joined as one word. At a low-word wrap, the high word is forwarded on the same cycle, so the port never shows a stale upper half for even one cycle.

A sync request zeroes the chain at a known point inside a serial frame. After the request, the block waits for the frame line to go high, then low, and then for the serial clock to be high. Only then does it arm a reset for every stage. Each stage takes that reset at its own next active event:

- The pulse generator takes it on the next serial edge, which then produces no pulse.
- The low counter takes it on the edge after that.
- The high counter takes it at the first low-word wrap.

After this, the low three bits read zero in the middle of a frame transfer. The ready output goes high once the high counter has been zeroed. A new sync request clears ready again. The count is a continuously valid level and the sync request is a plain strobe, so the block has no back-pressure: a consumer samples the count at any cycle and gets a coherent value.

Top module: `sclk_frame_counter`

## Requirements
- R1: While reset is held, the count output is 0 and ready is 0.
- R2: With no sync pending, each rising edge of the serial clock (high for at least two system cycles) adds exactly one to the count. The low LOW_W bits of the count are the low counter and the upper HIGH_W bits are the high counter.
- R3: When the low counter wraps from all ones to zero, the high counter advances by one. From cycle to cycle the count output steps by 0 or +1 and never passes through {old high, 0}.
- R4: A sync request has no effect on the count until the frame line has been seen high and then low after the request. Serial edges before that keep incrementing the count.
- R5: Arming happens once the frame line has gone low and the serial clock is high. After arming, the next serial edge does not change the count, and the edge after it sets the low word to 0. Each later edge k (counting the arming edge as 0) leaves the low word at k-2.
- R6: After arming, the high word keeps its value until the low word next wraps. At that wrap it becomes 0, and ready goes high and stays high until the next sync request.
- R7: Ready is 0 in the cycle after a sync request is sampled, and it stays 0 until R6 sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | External serial clock, asynchronous to clk |
| frame_in | input | 1 | External frame marker, asynchronous to clk |
| sync_req | input | 1 | One-cycle request to start frame alignment |
| count_o | output | LOW_W+HIGH_W | Joined high and low edge count |
| ready_o | output | 1 | High once alignment has completed and the high word has been zeroed |

## Verification
The hardest state to reach from the ports is the moment the high word is zeroed. It needs a full frame sequence to arm the chain, then a dropped edge, then a low-word reset, and then a complete low-word wrap. At the default width that is tens of thousands of serial edges. The bench instantiates the block with a 6-bit low word, which brings the wrap within reach. It models the frame-high, frame-low, serial-high sequence edge by edge, so every dropped and zeroing edge has an exact expected count. The stale-high-word case at a wrap appears for only one system cycle, so a per-cycle step monitor watches the count throughout the free-running phase.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    SY_IDLE,
    SY_WANT_FHI,
    SY_WANT_FLO,
    SY_WANT_SHI,
    SY_WAIT_WRAP,
    SY_DONE
  } sync_st_t;

endpackage

// File: rtl/fsc_input_sync.sv
module fsc_input_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] level_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[g]};
    end

    assign level_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/fsc_pulse_gen.sv
module fsc_pulse_gen #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_lvl_i,
  input  logic arm_i,
  output logic pulse_o
);

  localparam int CW = $clog2(TICKS + 1);

  logic          ser_prev;
  logic          ser_rise;
  logic          on_q;
  logic          div_q;
  logic [CW-1:0] tick_q;
  logic          pend_q;

  assign ser_rise = ser_lvl_i & ~ser_prev;
  assign pulse_o  = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_prev <= 1'b0;
      on_q     <= 1'b0;
      div_q    <= 1'b0;
      tick_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      ser_prev <= ser_lvl_i;
      if (arm_i) pend_q <= 1'b1;
      if (ser_rise) begin
        div_q  <= 1'b0;
        tick_q <= '0;
        if (pend_q) begin
          on_q <= 1'b0;
          if (!arm_i) pend_q <= 1'b0;
        end else begin
          on_q <= 1'b1;
        end
      end else if (on_q) begin
        div_q <= ~div_q;
        if (tick_q == CW'(TICKS)) on_q <= 1'b0;
        else if (div_q)            tick_q <= tick_q + 1'b1;
      end
    end
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |=> on_q);

endmodule

// File: rtl/fsc_low_count.sv
module fsc_low_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse_i,
  input  logic         arm_i,
  output logic [W-1:0] lo_o,
  output logic         carry_o
);

  logic         prev_q;
  logic         pend_q;
  logic [W-1:0] lo_q;
  logic         carry_q;
  logic         pedge;

  assign pedge   = pulse_i & ~prev_q;
  assign lo_o    = lo_q;
  assign carry_o = carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      lo_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      prev_q <= pulse_i;
      if (arm_i) pend_q <= 1'b1;
      if (pedge) begin
        if (pend_q) begin
          lo_q <= '0;
          if (!arm_i) pend_q <= 1'b0;
        end else begin
          lo_q <= lo_q + 1'b1;
          if (lo_q == '1)      carry_q <= 1'b1;
          else if (lo_q == '0) carry_q <= 1'b0;
        end
      end
    end
  end

  // R3
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_q) |-> lo_q == '0);

endmodule

// File: rtl/fsc_high_count.sv
module fsc_high_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         carry_i,
  input  logic         arm_i,
  output logic [W-1:0] hi_o,
  output logic         armed_o
);

  logic         prev_q;
  logic         pend_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] hi_next;
  logic         cedge;

  assign cedge   = carry_i & ~prev_q;
  assign hi_next = pend_q ? '0 : hi_q + 1'b1;
  assign hi_o    = cedge ? hi_next : hi_q;
  assign armed_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      prev_q <= carry_i;
      if (arm_i) pend_q <= 1'b1;
      if (cedge) begin
        hi_q <= hi_next;
        if (pend_q && !arm_i) pend_q <= 1'b0;
      end
    end
  end

  // R6
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_i && !prev_q) |=> $stable(hi_q));

endmodule

// File: rtl/fsc_sync_ctrl.sv
module fsc_sync_ctrl
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_req,
  input  logic frame_lvl,
  input  logic ser_lvl,
  input  logic hi_armed,
  output logic arm_o,
  output logic ready_o
);

  sync_st_t st_q;
  logic     ready_q;

  assign arm_o   = (st_q == SY_WANT_SHI) && ser_lvl && !sync_req;
  assign ready_o = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SY_IDLE;
      ready_q <= 1'b0;
    end else if (sync_req) begin
      st_q    <= SY_WANT_FHI;
      ready_q <= 1'b0;
    end else begin
      unique case (st_q)
        SY_WANT_FHI:  if (frame_lvl)  st_q <= SY_WANT_FLO;
        SY_WANT_FLO:  if (!frame_lvl) st_q <= SY_WANT_SHI;
        SY_WANT_SHI:  if (ser_lvl)    st_q <= SY_WAIT_WRAP;
        SY_WAIT_WRAP: if (!hi_armed) begin
          st_q    <= SY_DONE;
          ready_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !ready_q);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !sync_req |=> ready_q);

  // R4
  arm_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> st_q == SY_WAIT_WRAP && hi_armed);

endmodule

// File: rtl/sclk_frame_counter.sv
module sclk_frame_counter #(
  parameter int LOW_W       = 16,
  parameter int HIGH_W      = 16,
  parameter int PULSE_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             frame_in,
  input  logic             sync_req,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);

  logic [1:0]        lvl;
  logic              arm;
  logic              pulse;
  logic [LOW_W-1:0]  lo;
  logic              carry;
  logic [HIGH_W-1:0] hi;
  logic              hi_armed;

  fsc_input_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({frame_in, ser_clk}),
    .level_o (lvl)
  );

  fsc_sync_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_req  (sync_req),
    .frame_lvl (lvl[1]),
    .ser_lvl   (lvl[0]),
    .hi_armed  (hi_armed),
    .arm_o     (arm),
    .ready_o   (ready_o)
  );

  fsc_pulse_gen #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_lvl_i (lvl[0]),
    .arm_i     (arm),
    .pulse_o   (pulse)
  );

  fsc_low_count #(.W(LOW_W)) u_low (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (pulse),
    .arm_i   (arm),
    .lo_o    (lo),
    .carry_o (carry)
  );

  fsc_high_count #(.W(HIGH_W)) u_high (
    .clk     (clk),
    .rst_n   (rst_n),
    .carry_i (carry),
    .arm_i   (arm),
    .hi_o    (hi),
    .armed_o (hi_armed)
  );

  assign count_o = {hi, lo};

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> count_o == '0 && !ready_o);

endmodule

// File: tb/sim_sclk_frame_counter.sv
module sim_sclk_frame_counter;

  localparam int LW = 6;
  localparam int HW = 6;
  localparam int CW = LW + HW;

  typedef struct {
    logic [CW-1:0] cnt;
    bit            rdy;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_clk = 1'b0;
  logic          frame_in = 1'b0;
  logic          sync_req = 1'b0;
  logic [CW-1:0] count_o;
  logic          ready_o;

  int total = 0;
  int bad   = 0;

  exp_t sb_q[$];
  event smp;

  // reference model state
  logic [LW-1:0] m_lo = '0;
  logic [HW-1:0] m_hi = '0;
  bit pg_p = 0, lo_p = 0, hi_p = 0;
  int m_st = 0;
  bit m_ready = 0;
  string cur_tag = "R2";
  bit step_en = 0;

  always #4 clk = ~clk;

  sclk_frame_counter #(.LOW_W(LW), .HIGH_W(HW)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .frame_in (frame_in),
    .sync_req (sync_req),
    .count_o  (count_o),
    .ready_o  (ready_o)
  );

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit frm);
    bit arm_now = 0;
    if (m_st == 1 && frm) m_st = 2;
    else if (m_st == 2 && !frm) begin m_st = 3; arm_now = 1; end
    if (pg_p) pg_p = 0;
    else if (lo_p) begin m_lo = '0; lo_p = 0; end
    else begin
      if (m_lo == '1) begin
        if (hi_p) begin
          m_hi = '0; hi_p = 0;
          if (m_st == 3) begin m_st = 4; m_ready = 1; end
        end else m_hi = m_hi + 1'b1;
      end
      m_lo = m_lo + 1'b1;
    end
    if (arm_now) begin pg_p = 1; lo_p = 1; hi_p = 1; end
  endtask

  task automatic ser_cycle(bit frm);
    exp_t e;
    @(negedge clk);
    frame_in = frm;
    ser_clk  = 1'b1;
    model_edge(frm);
    repeat (10) @(negedge clk);
    ser_clk = 1'b0;
    repeat (10) @(negedge clk);
    e.cnt = {m_hi, m_lo};
    e.rdy = m_ready;
    e.tag = cur_tag;
    sb_q.push_back(e);
    -> smp;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    m_ready = 0;
    m_st = 1;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(smp);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, count_o, e.cnt);
        check({e.tag, " ready"}, CW'(ready_o), CW'(e.rdy));
      end
    end
  end

  // per-cycle step monitor, R3: never a stale high word at a wrap
  initial begin
    logic [CW-1:0] prev;
    prev = '0;
    forever begin
      @(negedge clk);
      if (step_en) begin
        logic [CW-1:0] d;
        d = count_o - prev;
        check("R3 step", CW'(d <= 1), CW'(1));
      end
      prev = count_o;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 count", count_o, '0);
    check("R1 ready", CW'(ready_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R3 free running across a low wrap
    cur_tag = "R2";
    step_en = 1;
    for (int i = 0; i < 70; i++) begin
      cur_tag = (i >= 62 && i <= 66) ? "R3" : "R2";
      ser_cycle(1'b0);
    end
    step_en = 0;

    // R4 request with frame held low: no reset
    pulse_req();
    cur_tag = "R4";
    for (int i = 0; i < 5; i++) ser_cycle(1'b0);

    // R5 alignment: frame high, frame low (arming edge), dropped edge, zeroing edge
    cur_tag = "R5";
    ser_cycle(1'b1);
    ser_cycle(1'b0);
    for (int i = 0; i < 4; i++) ser_cycle(1'b0);

    // R6 high word held until the first wrap, then zero and ready
    cur_tag = "R6";
    for (int i = 0; i < 68; i++) ser_cycle(1'b0);

    // R7 new request drops ready
    pulse_req();
    check("R7 ready", CW'(ready_o), '0);
    cur_tag = "R7";
    for (int i = 0; i < 3; i++) ser_cycle(1'b0);

    // second alignment from a non-zero high word
    cur_tag = "R5";
    ser_cycle(1'b1);
    ser_cycle(1'b0);
    for (int i = 0; i < 4; i++) ser_cycle(1'b0);
    cur_tag = "R6";
    for (int i = 0; i < 66; i++) ser_cycle(1'b0);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule